// File: doc/BRIEF.md
# Two-Level Sleep Controller

This block sits beside a small CPU core and handles its low-power entry and exit. When the core issues a sleep strobe, the controller checks two control bits. It then either halts the CPU in a light sleep state, or halts it in a deeper state that also gates the DMA engine's clock, or, when the standby bit is set, only passes the request on as a standby request. Full clock stop is not built here.

While either sleep state is active, any pending interrupt wakes the core, even when the core's interrupt-block bit is set. The sources are non-maskable, external level and peripheral. On a wake, the controller picks the winning source by fixed priority, latches its event code for software, and pulses a wake indication that starts exception handling. Any reset request forces the controller back to run. The reset requests are power-on or manual, from the pin or from the watchdog. Two status pins report whether the core is running or sleeping.

Top module: `slp_ctrl`

## Requirements
- R1: After `rst_n` is released, the block is in run: `cpu_halt`=0, `dma_clk_en`=1, `stat1`=0, `stat0`=0, `wake_vld`=0, `standby_req`=0 and `evt_code`=0.
- R2: In run, a `sleep_stb` with `stby_bit`=0 and `dslp_bit`=0 enters light sleep at the next clock edge: `cpu_halt`=1 and `dma_clk_en` stays 1.
- R3: In run, a `sleep_stb` with `stby_bit`=0 and `dslp_bit`=1 enters deep sleep at the next edge: `cpu_halt`=1 and `dma_clk_en`=0. `dma_clk_en` is 0 only in deep sleep.
- R4: `ckout_en` is 1 in run, light sleep and deep sleep.
- R5: In run, a `sleep_stb` with `stby_bit`=1 gives a one-cycle `standby_req` pulse at the next edge, and the block stays in run.
- R6: In either sleep state, a request on `irq_nmi`, a nonzero `irq_ext_lvl` or `irq_per` returns the block to run at the next edge. At that edge `cpu_halt` falls and `wake_vld` is 1 for exactly one cycle.
- R7: `blk_bit` has no effect on wake-up from either sleep state.
- R8: On a wake, `evt_code` takes the code of the highest-priority pending source. Priority is NMI first (code `NMI_CODE`, default 0x1C0), then external level (code `EXT_BASE` + 32×level, default base 0x200), then peripheral (the value on `per_code`). At all other times `evt_code` holds its value.
- R9: Any of `por_pin`, `mrst_pin`, `wdt_por` or `wdt_mrst` forces run at the next edge, with `dma_clk_en`=1 and no `wake_vld`. Reset requests win over a sleep strobe and over interrupts.
- R10: In run, interrupt requests neither produce `wake_vld` nor change `evt_code`.
- R11: The status pins read `stat1`=1, `stat0`=0 in either sleep state and `stat1`=0, `stat0`=0 in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_stb | input | 1 | Sleep instruction strobe from the core |
| stby_bit | input | 1 | Standby control bit |
| dslp_bit | input | 1 | Deep-sleep select bit |
| blk_bit | input | 1 | Core interrupt-block bit |
| irq_nmi | input | 1 | Non-maskable interrupt request |
| irq_ext_lvl | input | 4 | External interrupt level, 0 = none |
| irq_per | input | 1 | Peripheral interrupt request |
| per_code | input | CODE_W | Event code of the peripheral request |
| por_pin | input | 1 | Power-on reset request from pin |
| mrst_pin | input | 1 | Manual reset request from pin |
| wdt_por | input | 1 | Power-on reset request from watchdog |
| wdt_mrst | input | 1 | Manual reset request from watchdog |
| cpu_halt | output | 1 | CPU halt |
| dma_clk_en | output | 1 | DMA clock enable |
| ckout_en | output | 1 | External clock output enable |
| stat1 | output | 1 | Status pin 1 |
| stat0 | output | 1 | Status pin 0 |
| standby_req | output | 1 | Standby request pulse |
| wake_vld | output | 1 | Wake pulse, start exception handling |
| evt_code | output | CODE_W | Latched interrupt event code |

## Verification
The checker tests on every cycle that a sleep strobe halts the core and that a pending interrupt in sleep brings a wake pulse at the next edge. It also checks that reset requests force run, that the DMA gate is off only while halted, that the status pins follow the halt, that the clock output stays on, and that the event code stays still without a wake. Only the bench's reference model can show which source wins when several are pending and the exact code it latches. The same holds for `blk_bit` having no effect, and for deep and light sleep being told apart correctly over long random runs.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_LIGHT = 2'd1,
        ST_DEEP  = 2'd2
    } slp_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_PER  = 2'd3
    } wake_src_e;
endpackage

// File: rtl/slp_wake_arb.sv
module slp_wake_arb #(
    parameter int CODE_W   = 12,
    parameter int LVL_W    = 4,
    parameter int LVL_SH   = 5,
    parameter logic [CODE_W-1:0] NMI_CODE = 12'h1C0,
    parameter logic [CODE_W-1:0] EXT_BASE = 12'h200
) (
    input  logic              irq_nmi,
    input  logic [LVL_W-1:0]  irq_ext_lvl,
    input  logic              irq_per,
    input  logic [CODE_W-1:0] per_code,
    output logic              any_vld,
    output slp_pkg::wake_src_e win_src,
    output logic [CODE_W-1:0] win_code
);
    import slp_pkg::*;

    localparam int EXT_W = LVL_W + LVL_SH;

    logic              ext_req;
    logic [CODE_W-1:0] ext_code;

    assign ext_req  = |irq_ext_lvl;
    assign ext_code = EXT_BASE + CODE_W'({irq_ext_lvl, {LVL_SH{1'b0}}});

    always_comb begin
        win_src  = SRC_NONE;
        win_code = '0;
        if (irq_nmi) begin
            win_src  = SRC_NMI;
            win_code = NMI_CODE;
        end else if (ext_req) begin
            win_src  = SRC_EXT;
            win_code = ext_code;
        end else if (irq_per) begin
            win_src  = SRC_PER;
            win_code = per_code;
        end
    end

    assign any_vld = (win_src != SRC_NONE);

    if (EXT_W > CODE_W) begin : g_bad_width
        initial $error("slp_wake_arb: CODE_W too small for level code");
    end
endmodule

// File: rtl/slp_entry_dec.sv
module slp_entry_dec (
    input  logic sleep_stb,
    input  logic stby_bit,
    input  logic dslp_bit,
    input  logic in_run,
    output logic go_light,
    output logic go_deep,
    output logic go_stby
);
    logic take;

    assign take     = sleep_stb & in_run;
    assign go_stby  = take & stby_bit;
    assign go_light = take & ~stby_bit & ~dslp_bit;
    assign go_deep  = take & ~stby_bit & dslp_bit;
endmodule

// File: rtl/slp_status_enc.sv
module slp_status_enc (
    input  slp_pkg::slp_state_e state,
    output logic cpu_halt,
    output logic dma_clk_en,
    output logic ckout_en,
    output logic stat1,
    output logic stat0
);
    import slp_pkg::*;

    always_comb begin
        cpu_halt   = 1'b0;
        dma_clk_en = 1'b1;
        ckout_en   = 1'b1;
        stat1      = 1'b0;
        stat0      = 1'b0;
        unique case (state)
            ST_LIGHT: begin
                cpu_halt = 1'b1;
                stat1    = 1'b1;
            end
            ST_DEEP: begin
                cpu_halt   = 1'b1;
                dma_clk_en = 1'b0;
                stat1      = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl #(
    parameter int CODE_W   = 12,
    parameter int LVL_W    = 4,
    parameter logic [CODE_W-1:0] NMI_CODE = 12'h1C0,
    parameter logic [CODE_W-1:0] EXT_BASE = 12'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_stb,
    input  logic              stby_bit,
    input  logic              dslp_bit,
    input  logic              blk_bit,
    input  logic              irq_nmi,
    input  logic [LVL_W-1:0]  irq_ext_lvl,
    input  logic              irq_per,
    input  logic [CODE_W-1:0] per_code,
    input  logic              por_pin,
    input  logic              mrst_pin,
    input  logic              wdt_por,
    input  logic              wdt_mrst,
    output logic              cpu_halt,
    output logic              dma_clk_en,
    output logic              ckout_en,
    output logic              stat1,
    output logic              stat0,
    output logic              standby_req,
    output logic              wake_vld,
    output logic [CODE_W-1:0] evt_code
);
    import slp_pkg::*;

    localparam int LVL_SH = 5;

    typedef struct packed {
        slp_state_e        state;
        logic              wake;
        logic              stby;
        logic [CODE_W-1:0] code;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    logic              rst_any;
    logic              in_run;
    logic              go_light, go_deep, go_stby;
    logic              irq_vld;
    logic              wake_ok;
    wake_src_e         win_src;
    logic [CODE_W-1:0] win_code;

    assign rst_any = por_pin | mrst_pin | wdt_por | wdt_mrst;
    assign in_run  = (r_q.state == ST_RUN);

    slp_entry_dec u_entry (
        .sleep_stb (sleep_stb),
        .stby_bit  (stby_bit),
        .dslp_bit  (dslp_bit),
        .in_run    (in_run),
        .go_light  (go_light),
        .go_deep   (go_deep),
        .go_stby   (go_stby)
    );

    slp_wake_arb #(
        .CODE_W   (CODE_W),
        .LVL_W    (LVL_W),
        .LVL_SH   (LVL_SH),
        .NMI_CODE (NMI_CODE),
        .EXT_BASE (EXT_BASE)
    ) u_arb (
        .irq_nmi     (irq_nmi),
        .irq_ext_lvl (irq_ext_lvl),
        .irq_per     (irq_per),
        .per_code    (per_code),
        .any_vld     (irq_vld),
        .win_src     (win_src),
        .win_code    (win_code)
    );

    // The block bit only matters while running; a sleeping core accepts all.
    assign wake_ok = irq_vld & (~in_run | ~blk_bit) & (win_src != SRC_NONE);

    always_comb begin
        r_d      = r_q;
        r_d.wake = 1'b0;
        r_d.stby = 1'b0;
        if (rst_any) begin
            r_d.state = ST_RUN;
        end else begin
            unique case (r_q.state)
                ST_RUN: begin
                    if (go_light) r_d.state = ST_LIGHT;
                    if (go_deep)  r_d.state = ST_DEEP;
                    r_d.stby = go_stby;
                end
                ST_LIGHT, ST_DEEP: begin
                    if (wake_ok) begin
                        r_d.state = ST_RUN;
                        r_d.wake  = 1'b1;
                        r_d.code  = win_code;
                    end
                end
                default: r_d.state = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_RUN, wake: 1'b0, stby: 1'b0, code: '0};
        end else begin
            r_q <= r_d;
        end
    end

    slp_status_enc u_stat (
        .state      (r_q.state),
        .cpu_halt   (cpu_halt),
        .dma_clk_en (dma_clk_en),
        .ckout_en   (ckout_en),
        .stat1      (stat1),
        .stat0      (stat0)
    );

    assign standby_req = r_q.stby;
    assign wake_vld    = r_q.wake;
    assign evt_code    = r_q.code;
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk #(
    parameter int CODE_W = 12,
    parameter int LVL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_stb,
    input logic              stby_bit,
    input logic              irq_nmi,
    input logic [LVL_W-1:0]  irq_ext_lvl,
    input logic              irq_per,
    input logic              por_pin,
    input logic              mrst_pin,
    input logic              wdt_por,
    input logic              wdt_mrst,
    input logic              cpu_halt,
    input logic              dma_clk_en,
    input logic              ckout_en,
    input logic              stat1,
    input logic              stat0,
    input logic              standby_req,
    input logic              wake_vld,
    input logic [CODE_W-1:0] evt_code
);
    logic rst_any, irq_any;
    assign rst_any = por_pin | mrst_pin | wdt_por | wdt_mrst;
    assign irq_any = irq_nmi | (|irq_ext_lvl) | irq_per;

    a_r2_strobe_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_halt && sleep_stb && !stby_bit && !rst_any) |=> cpu_halt);

    a_r3_dma_off_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_clk_en |-> cpu_halt);

    a_r4_clock_out_on: assert property (@(posedge clk) disable iff (!rst_n)
        ckout_en);

    a_r5_standby_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        standby_req |-> !cpu_halt);

    a_r6_irq_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && irq_any && !rst_any) |=> (!cpu_halt && wake_vld));

    a_r8_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_vld |-> $stable(evt_code));

    a_r9_reset_forces_run: assert property (@(posedge clk) disable iff (!rst_n)
        rst_any |=> (!cpu_halt && dma_clk_en && !wake_vld));

    a_r11_status_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0 == 1'b0) && (stat1 == cpu_halt));
endmodule

bind slp_ctrl slp_ctrl_chk #(.CODE_W(CODE_W), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/slp_ctrl_bench.sv
module slp_ctrl_bench;
    localparam int CW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_stb = 0, stby_bit = 0, dslp_bit = 0, blk_bit = 0;
    logic irq_nmi = 0, irq_per = 0;
    logic [3:0] irq_ext_lvl = '0;
    logic [CW-1:0] per_code = '0;
    logic por_pin = 0, mrst_pin = 0, wdt_por = 0, wdt_mrst = 0;
    logic cpu_halt, dma_clk_en, ckout_en, stat1, stat0, standby_req, wake_vld;
    logic [CW-1:0] evt_code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model: 0 run, 1 light sleep, 2 deep sleep
    int m_st = 0;
    bit m_wake = 0, m_stby = 0;
    logic [CW-1:0] m_code = '0;

    always #10 clk = ~clk;

    slp_ctrl u_slp_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_stb(sleep_stb), .stby_bit(stby_bit),
        .dslp_bit(dslp_bit), .blk_bit(blk_bit), .irq_nmi(irq_nmi),
        .irq_ext_lvl(irq_ext_lvl), .irq_per(irq_per), .per_code(per_code),
        .por_pin(por_pin), .mrst_pin(mrst_pin), .wdt_por(wdt_por), .wdt_mrst(wdt_mrst),
        .cpu_halt(cpu_halt), .dma_clk_en(dma_clk_en), .ckout_en(ckout_en),
        .stat1(stat1), .stat0(stat0), .standby_req(standby_req),
        .wake_vld(wake_vld), .evt_code(evt_code)
    );

    function automatic logic [CW-1:0] exp_code(input logic nmi, input logic [3:0] lvl,
                                               input logic per, input logic [CW-1:0] pc);
        if (nmi) return 12'h1C0;
        if (lvl != 0) return 12'h200 + {3'b0, lvl, 5'b0};
        if (per) return pc;
        return '0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_wake = 0; m_stby = 0; m_code = '0;
        end else begin
            m_wake = 0; m_stby = 0;
            if (por_pin | mrst_pin | wdt_por | wdt_mrst) m_st = 0;
            else if (m_st == 0) begin
                if (sleep_stb && stby_bit) m_stby = 1;
                else if (sleep_stb) m_st = dslp_bit ? 2 : 1;
            end else if (irq_nmi || irq_ext_lvl != 0 || irq_per) begin
                m_st = 0; m_wake = 1;
                m_code = exp_code(irq_nmi, irq_ext_lvl, irq_per, per_code);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(cpu_halt == (m_st != 0), "R2 halt", cpu_halt, m_st != 0);
        chk(dma_clk_en == (m_st != 2), "R3 dma gate", dma_clk_en, m_st != 2);
        chk(ckout_en == 1'b1, "R4 clock out", ckout_en, 1);
        chk(standby_req == m_stby, "R5 standby", standby_req, m_stby);
        chk(wake_vld == m_wake, "R6 wake", wake_vld, m_wake);
        chk(evt_code == m_code, "R8 code", evt_code, m_code);
        chk({stat1, stat0} == ((m_st != 0) ? 2'b10 : 2'b00), "R11 status",
            {stat1, stat0}, (m_st != 0) ? 2'b10 : 2'b00);
    endtask

    task automatic idle();
        sleep_stb = 0; stby_bit = 0; dslp_bit = 0; blk_bit = 0;
        irq_nmi = 0; irq_ext_lvl = 0; irq_per = 0;
        por_pin = 0; mrst_pin = 0; wdt_por = 0; wdt_mrst = 0;
    endtask

    task automatic step();
        @(negedge clk);
        check_all();
    endtask

    task automatic enter(input bit deep);
        sleep_stb = 1; dslp_bit = deep; step(); idle();
    endtask

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!cpu_halt && dma_clk_en && {stat1, stat0} == 2'b00 && !wake_vld
            && !standby_req && evt_code == 0, "R1 reset",
            {cpu_halt, dma_clk_en, stat1, stat0, wake_vld, standby_req}, 6'b010000);

        // R2 light sleep, then R7 wake with blk_bit set, peripheral code
        enter(0);
        chk(cpu_halt && dma_clk_en, "R2 light", {cpu_halt, dma_clk_en}, 2'b11);
        blk_bit = 1; irq_per = 1; per_code = 12'h3A4; step(); idle();
        chk(wake_vld && !cpu_halt && evt_code == 12'h3A4, "R7 blk ignored",
            evt_code, 12'h3A4);
        step();
        chk(!wake_vld, "R6 single pulse", wake_vld, 0);

        // R3 deep sleep, R8 priority with all three pending
        enter(1);
        chk(cpu_halt && !dma_clk_en, "R3 deep", {cpu_halt, dma_clk_en}, 2'b10);
        irq_nmi = 1; irq_ext_lvl = 4'd7; irq_per = 1; per_code = 12'h055; step(); idle();
        chk(evt_code == 12'h1C0, "R8 nmi first", evt_code, 12'h1C0);
        enter(0);
        irq_ext_lvl = 4'd15; irq_per = 1; step(); idle();
        chk(evt_code == 12'h3E0, "R8 ext over per", evt_code, 12'h3E0);

        // R10 interrupts in run do nothing
        irq_nmi = 1; irq_per = 1; per_code = 12'h111; step(); step(); idle();
        chk(!wake_vld && evt_code == 12'h3E0, "R10 run irq", evt_code, 12'h3E0);

        // R5 standby strobe
        sleep_stb = 1; stby_bit = 1; step(); idle();
        chk(standby_req && !cpu_halt, "R5 standby pulse", standby_req, 1);

        // R9 reset beats interrupt and strobe
        enter(1);
        wdt_mrst = 1; irq_nmi = 1; step(); idle();
        chk(!cpu_halt && dma_clk_en && !wake_vld && evt_code == 12'h3E0,
            "R9 reset wins", {cpu_halt, wake_vld}, 0);
        por_pin = 1; sleep_stb = 1; step(); idle();
        chk(!cpu_halt, "R9 reset over strobe", cpu_halt, 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            sleep_stb   = ($urandom % 5) == 0;
            stby_bit    = ($urandom % 5) == 0;
            dslp_bit    = $urandom % 2;
            blk_bit     = $urandom % 2;
            irq_nmi     = ($urandom % 40) == 0;
            irq_ext_lvl = (($urandom % 12) == 0) ? 4'($urandom) : 4'd0;
            irq_per     = ($urandom % 12) == 0;
            per_code    = CW'($urandom);
            por_pin     = ($urandom % 200) == 0;
            mrst_pin    = ($urandom % 200) == 0;
            wdt_por     = ($urandom % 200) == 0;
            wdt_mrst    = ($urandom % 200) == 0;
            step();
        end
        idle();
        step();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule